// File: doc/BRIEF.md
# Single-Byte I/O Target for a Low Pin Count Host Bus

This block sits on the peripheral side of a Low Pin Count (LPC) bus that runs on the 33 MHz PCI clock. It watches the 4-bit multiplexed address/data lines together with the active-low frame strobe. It claims single-byte I/O read and I/O write cycles whose 16-bit address falls inside an aligned window of `2**WIN_BITS` bytes based at `BASE_ADDR`. Each claimed access is handed to a plain internal register port. A write produces one write strobe with an offset and a byte. A read produces one read strobe with an offset, and the byte is taken from the read-data input.

The block leaves the bus lines undriven except during its own sync, read-data and turnaround slots. The bus pins are split into an input nibble, an output nibble and an output enable, so the pad cell lies outside the block. Cycle types other than I/O read and I/O write, and start codes other than the plain start code, are ignored without any response. A low frame strobe sampled on any clock ends whatever was in progress, and the bus is released from the next clock on. The clock is assumed to run without interruption.

Top module: `lpc_io_target`

## Requirements
- R1: While `rstN` is low the block does not drive the bus (`ladOe` = 0) and both `regWr` and `regRd` stay at 0. After reset it waits for a start.
- R2: A claimed I/O write asserts `regWr` for exactly one clock, in the sync slot. During that clock `regAddr` holds the low `WIN_BITS` address bits and `regWdata` holds the byte sent in the two data nibbles, low nibble first.
- R3: On a claimed write, the block drives `ladOut` = 0000 (sync, ready) in the sync slot and 1111 in the next slot. In every other slot of the cycle, and from the following slot on, the bus is released.
- R4: A claimed I/O read asserts `regRd` for exactly one clock. That clock is the sync slot, which directly follows the two host turnaround clocks. During it `ladOut` = 0000 is driven and `regAddr` holds the offset.
- R5: On a claimed read, `regRdata` is captured at the end of the sync slot. The block then drives its low nibble and, in the next slot, its high nibble. It drives 1111 for one slot and releases the bus after that.
- R6: The address is taken as four nibbles, most significant first. An address whose bits 15..`WIN_BITS` differ from those of `BASE_ADDR` is not claimed: there is no strobe and the bus is not driven.
- R7: A cycle-type nibble other than 0000 (I/O read) or 0010 (I/O write) is ignored. So is a start nibble other than 0000 while the frame strobe is low. In both cases there is no strobe and no drive until the next start.
- R8: When `frameN` is sampled low in any slot, `ladOe` is 0 from the next slot on and the interrupted cycle produces no further strobe. A fresh start is then accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (33 MHz PCI clock) |
| rstN | input | 1 | Active-low PCI reset |
| frameN | input | 1 | Active-low cycle start / abort strobe |
| ladIn | input | 4 | Nibble sampled from the bus lines |
| ladOut | output | 4 | Nibble driven onto the bus lines when enabled |
| ladOe | output | 1 | Enable for driving `ladOut` onto the bus |
| regAddr | output | WIN_BITS | Offset of the access inside the window |
| regWdata | output | 8 | Write byte, valid while `regWr` is high |
| regWr | output | 1 | One-clock write strobe |
| regRd | output | 1 | One-clock read strobe |
| regRdata | input | 8 | Read byte, sampled at the end of the `regRd` clock |
| | | | |

## Verification
Slots are counted from the start slot 0 (frame low, 0000). A write's strobe and sync are due in slot 10, its 1111 in slot 11 and the release in slot 12. A read's strobe and sync are due in slot 8, its data nibbles in slots 9 and 10, its 1111 in slot 11 and the release in slot 12. An abort in slot k is due to clear all drive from slot k+1 on. The bench drives one nibble per clock on the falling edge and samples every output a moment later, so each sample shows the registered state left by the preceding rising edge. It compares that sample with the slot table above, slot by slot, for every cycle it issues.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE,
    ST_ADR0, ST_ADR1, ST_ADR2, ST_ADR3,
    ST_WDLO, ST_WDHI,
    ST_HTA0, ST_HTA1,
    ST_SYNC,
    ST_RDLO, ST_RDHI,
    ST_TTAR
  } lpcState_t;

  typedef enum logic [1:0] {
    DRV_SYNC, DRV_LO, DRV_HI, DRV_ONES
  } ladSel_t;

  typedef struct packed {
    logic    shiftAddr;
    logic    capLo;
    logic    capHi;
    logic    latchRd;
    logic    drive;
    ladSel_t sel;
  } dpCtrl_t;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_IORD  = 4'b0000;
  localparam logic [3:0] NIB_IOWR  = 4'b0010;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_ONES  = 4'b1111;

endpackage

// File: rtl/lpc_io_ctrl.sv
module lpc_io_ctrl
  import lpc_io_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] ladIn,
  input  logic       addrHit,
  output dpCtrl_t    ctrl,
  output logic       regWr,
  output logic       regRd
);

  lpcState_t state, nextState;
  logic      isWr, nextIsWr;

  always_comb begin
    nextState = state;
    nextIsWr  = isWr;
    case (state)
      ST_IDLE: nextState = ST_IDLE;
      ST_TYPE: begin
        if (ladIn == NIB_IORD) begin
          nextState = ST_ADR0;
          nextIsWr  = 1'b0;
        end else if (ladIn == NIB_IOWR) begin
          nextState = ST_ADR0;
          nextIsWr  = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_ADR0: nextState = ST_ADR1;
      ST_ADR1: nextState = ST_ADR2;
      ST_ADR2: nextState = ST_ADR3;
      ST_ADR3: begin
        if (!addrHit)  nextState = ST_IDLE;
        else if (isWr) nextState = ST_WDLO;
        else           nextState = ST_HTA0;
      end
      ST_WDLO: nextState = ST_WDHI;
      ST_WDHI: nextState = ST_HTA0;
      ST_HTA0: nextState = ST_HTA1;
      ST_HTA1: nextState = ST_SYNC;
      ST_SYNC: nextState = isWr ? ST_TTAR : ST_RDLO;
      ST_RDLO: nextState = ST_RDHI;
      ST_RDHI: nextState = ST_TTAR;
      ST_TTAR: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    // frame strobe overrides everything: new start or abort
    if (!frameN) begin
      nextState = (ladIn == NIB_START) ? ST_TYPE : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isWr  <= 1'b0;
    end else begin
      state <= nextState;
      isWr  <= nextIsWr;
    end
  end

  always_comb begin
    ctrl.shiftAddr = (state == ST_ADR0) || (state == ST_ADR1) ||
                     (state == ST_ADR2) || (state == ST_ADR3);
    ctrl.capLo     = (state == ST_WDLO);
    ctrl.capHi     = (state == ST_WDHI);
    ctrl.latchRd   = (state == ST_SYNC) && !isWr;
    ctrl.drive     = (state == ST_SYNC) || (state == ST_RDLO) ||
                     (state == ST_RDHI) || (state == ST_TTAR);
    case (state)
      ST_RDLO: ctrl.sel = DRV_LO;
      ST_RDHI: ctrl.sel = DRV_HI;
      ST_TTAR: ctrl.sel = DRV_ONES;
      default: ctrl.sel = DRV_SYNC;
    endcase
  end

  assign regWr = (state == ST_SYNC) && isWr;
  assign regRd = (state == ST_SYNC) && !isWr;

endmodule

// File: rtl/lpc_io_datapath.sv
module lpc_io_datapath
  import lpc_io_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0380,
  parameter int          WIN_BITS  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          ladIn,
  input  dpCtrl_t             ctrl,
  input  logic [7:0]          regRdata,
  output logic                addrHit,
  output logic [WIN_BITS-1:0] regAddr,
  output logic [7:0]          regWdata,
  output logic [3:0]          ladOut,
  output logic                ladOe
);

  localparam int ADDR_W = 16;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] fullAddr;
  logic [7:0]        wrByteQ;
  logic [7:0]        rdByteQ;

  // address as it stands once the current nibble is shifted in
  assign fullAddr = {addrQ[ADDR_W-5:0], ladIn};
  assign addrHit  = (fullAddr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrByteQ <= '0;
      rdByteQ <= '0;
    end else begin
      if (ctrl.shiftAddr) addrQ        <= fullAddr;
      if (ctrl.capLo)     wrByteQ[3:0] <= ladIn;
      if (ctrl.capHi)     wrByteQ[7:4] <= ladIn;
      if (ctrl.latchRd)   rdByteQ      <= regRdata;
    end
  end

  always_comb begin
    case (ctrl.sel)
      DRV_LO:   ladOut = rdByteQ[3:0];
      DRV_HI:   ladOut = rdByteQ[7:4];
      DRV_ONES: ladOut = NIB_ONES;
      default:  ladOut = NIB_READY;
    endcase
  end

  assign ladOe    = ctrl.drive;
  assign regAddr  = addrQ[WIN_BITS-1:0];
  assign regWdata = wrByteQ;

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_io_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0380,
  parameter int          WIN_BITS  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameN,
  input  logic [3:0]          ladIn,
  output logic [3:0]          ladOut,
  output logic                ladOe,
  output logic [WIN_BITS-1:0] regAddr,
  output logic [7:0]          regWdata,
  output logic                regWr,
  output logic                regRd,
  input  logic [7:0]          regRdata
);

  dpCtrl_t ctrl;
  logic    addrHit;

  lpc_io_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .ladIn   (ladIn),
    .addrHit (addrHit),
    .ctrl    (ctrl),
    .regWr   (regWr),
    .regRd   (regRd)
  );

  lpc_io_datapath #(
    .BASE_ADDR (BASE_ADDR),
    .WIN_BITS  (WIN_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ladIn    (ladIn),
    .ctrl     (ctrl),
    .regRdata (regRdata),
    .addrHit  (addrHit),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ladOut   (ladOut),
    .ladOe    (ladOe)
  );

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameN,
  input logic [3:0] ladOut,
  input logic       ladOe,
  input logic       regWr,
  input logic       regRd
);

  // R1: reset holds the bus released and the strobes low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!ladOe && !regWr && !regRd));

  // R8: a sampled frame strobe releases the bus on the next clock
  a_r8_frame_release: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !ladOe);

  // R2: write strobe lasts one clock and coincides with a ready sync
  a_r2_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr);
  a_r2_wr_sync: assert property (@(posedge clk) disable iff (!rstN)
    regWr |-> (ladOe && ladOut == 4'b0000));

  // R3: after the write sync the target drives all ones once
  a_r3_wr_tar: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && frameN) |=> (ladOe && ladOut == 4'b1111));

  // R4: read strobe lasts one clock and coincides with a ready sync
  a_r4_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd);
  a_r4_rd_sync: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (ladOe && ladOut == 4'b0000));

  // R5: read data follows the read sync on the bus
  a_r5_rd_data: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && frameN) |=> ladOe);

  // R2 / R4: a cycle is either a read or a write, never both
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .frameN (frameN),
  .ladOut (ladOut),
  .ladOe  (ladOe),
  .regWr  (regWr),
  .regRd  (regRd)
);

// File: tb/lpc_io_target_bench.sv
`timescale 1ns/1ps
module lpc_io_target_bench;

  localparam logic [15:0] BASE = 16'h0380;
  localparam int          WB   = 4;
  localparam int          NO_ABORT = 99;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameN = 1'b1;
  logic [3:0]    ladIn = 4'hF;
  logic [3:0]    ladOut;
  logic          ladOe;
  logic [WB-1:0] regAddr;
  logic [7:0]    regWdata;
  logic          regWr;
  logic          regRd;
  logic [7:0]    regRdata;
  logic [7:0]    mem [0:(1<<WB)-1];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign regRdata = mem[regAddr];

  lpc_io_target #(.BASE_ADDR(BASE), .WIN_BITS(WB)) u_lpc_io_target (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .regAddr(regAddr),
    .regWdata(regWdata), .regWr(regWr), .regRd(regRd), .regRdata(regRdata)
  );

  function automatic bit inWin(input logic [15:0] a);
    return a[15:WB] == BASE[15:WB];
  endfunction

  function automatic bit expOe(input bit cw, input bit cr, input int s);
    return (cw && (s == 10 || s == 11)) || (cr && s >= 8 && s <= 11);
  endfunction

  function automatic logic [3:0] expLad(input bit cw, input int s, input logic [7:0] d);
    if (cw) return (s == 10) ? 4'h0 : 4'hF;
    case (s)
      8:       return 4'h0;
      9:       return d[3:0];
      10:      return d[7:4];
      default: return 4'hF;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // One full bus cycle of 14 slots, checked slot by slot.
  task automatic runCycle(input logic [3:0] startNib, input logic [3:0] ctype,
                          input logic [15:0] addr, input logic [7:0] data,
                          input int abortAt);
    bit okStart = (startNib == 4'h0);
    bit isW = (ctype == 4'b0010);
    bit isR = (ctype == 4'b0000);
    bit hit = inWin(addr);
    logic [7:0] rdExp = mem[addr[WB-1:0]];
    for (int s = 0; s < 14; s++) begin
      logic       fr;
      logic [3:0] nib;
      bit live, cw, cr, ew, er, eo;
      string tagS, tagL;
      fr = (s == 0) ? 1'b0 : 1'b1;
      if (s == 0)                   nib = startNib;
      else if (s == 1)              nib = ctype;
      else if (s >= 2 && s <= 5)    nib = addr[15 - 4*(s-2) -: 4];
      else if (s == 6 && isW)       nib = data[3:0];
      else if (s == 7 && isW)       nib = data[7:4];
      else                          nib = 4'hF;
      if (s == abortAt) begin
        fr  = 1'b0;
        nib = 4'hF;
      end
      @(negedge clk);
      frameN = fr;
      ladIn  = nib;
      #1;
      live = (s <= abortAt);
      cw = live && okStart && isW && hit;
      cr = live && okStart && isR && hit;
      if (!live)                   begin tagS = "R8"; tagL = "R8"; end
      else if (!okStart || !(isW || isR)) begin tagS = "R7"; tagL = "R7"; end
      else if (!hit)               begin tagS = "R6"; tagL = "R6"; end
      else if (isW)                begin tagS = "R2"; tagL = "R3"; end
      else                         begin tagS = "R4"; tagL = "R5"; end
      eo = expOe(cw, cr, s);
      ew = cw && (s == 10);
      er = cr && (s == 8);
      chk(tagL, "ladOe", {15'd0, ladOe}, {15'd0, eo});
      if (eo) chk(tagL, "ladOut", {12'd0, ladOut}, {12'd0, expLad(cw, s, rdExp)});
      chk(tagS, "regWr", {15'd0, regWr}, {15'd0, ew});
      chk(tagS, "regRd", {15'd0, regRd}, {15'd0, er});
      if (ew) begin
        chk("R2", "regAddr", {12'd0, regAddr}, {12'd0, addr[WB-1:0]});
        chk("R2", "regWdata", {8'd0, regWdata}, {8'd0, data});
      end
      if (er) chk("R4", "regAddr", {12'd0, regAddr}, {12'd0, addr[WB-1:0]});
    end
  endtask

  function automatic logic [15:0] pickAddr;
    if ($urandom % 2) return {BASE[15:WB], 4'(($urandom % 16))};
    return 16'($urandom);
  endfunction

  initial begin
    logic [3:0] ct;
    void'($urandom(32'h5EED_0C0D));
    for (int i = 0; i < (1 << WB); i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "ladOe in reset", {15'd0, ladOe}, 16'd0);
    chk("R1", "regWr in reset", {15'd0, regWr}, 16'd0);
    chk("R1", "regRd in reset", {15'd0, regRd}, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed corner cases
    runCycle(4'h0, 4'b0010, BASE,          8'hA5, NO_ABORT); // R2 R3 window base
    runCycle(4'h0, 4'b0000, BASE + 16'd15, 8'h00, NO_ABORT); // R4 R5 window top
    runCycle(4'h0, 4'b0010, BASE - 16'd1,  8'h3C, NO_ABORT); // R6 just below
    runCycle(4'h0, 4'b0000, BASE + 16'd16, 8'h00, NO_ABORT); // R6 just above
    runCycle(4'h0, 4'b0100, BASE,          8'h11, NO_ABORT); // R7 other type
    runCycle(4'h5, 4'b0010, BASE,          8'h22, NO_ABORT); // R7 other start
    runCycle(4'h0, 4'b0010, BASE + 16'd3,  8'h5A, 3);        // R8 abort in address
    runCycle(4'h0, 4'b0010, BASE + 16'd4,  8'h6B, 10);       // R8 abort in write sync
    runCycle(4'h0, 4'b0000, BASE + 16'd5,  8'h00, 9);        // R8 abort in read data
    runCycle(4'h0, 4'b0000, BASE + 16'd6,  8'h00, NO_ABORT); // R8 new start accepted

    // constrained random cycles
    for (int n = 0; n < 300; n++) begin
      int kind = int'($urandom % 8);
      int ab   = (($urandom % 5) == 0) ? int'(1 + $urandom % 12) : NO_ABORT;
      if (kind < 3)       runCycle(4'h0, 4'b0010, pickAddr(), 8'($urandom), ab);
      else if (kind < 6)  runCycle(4'h0, 4'b0000, pickAddr(), 8'h00, ab);
      else if (kind == 6) begin
        ct = 4'($urandom % 16);
        if (ct == 4'h0 || ct == 4'h2) ct = 4'h4;
        runCycle(4'h0, ct, pickAddr(), 8'($urandom), ab);
      end else            runCycle(4'($urandom % 15 + 1), 4'b0010, BASE, 8'($urandom), ab);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the sequence ended");
      summary();
      $finish;
    end
  end

endmodule